// File: doc/BRIEF.md
# Timer Event Interrupt and Conversion Trigger Unit

This block gathers event strobes from a three-channel timer and turns them into latched status flags, masked interrupt request lines and a single conversion-start pulse for an analogue-to-digital converter. The counters and compare logic sit elsewhere. This block only sees one-cycle strobes for compare/capture match, counter overflow and counter underflow. Software reaches the flags and enable bits through a small register port.

The channels differ. Channel 0 has four match sources (A to D). Channels 1 and 2 have two (A and B). Every channel has overflow, but only channels 1 and 2 have underflow. Each flag is a small state machine with three states: FL_IDLE (clear), FL_PEND (set, not yet read as 1) and FL_ARMED (set and read as 1). Its transitions are:
- idle-to-pend on an event;
- pend-to-armed on a read of its status register;
- armed-to-idle on a write of 0 to its bit when no event arrives in the same cycle.

Any other combination holds the state.

A rising edge on a channel's match-A flag with that channel's trigger enable set requests a conversion. The request becomes a pulse on `adc_start` only when `adc_sel` shows that the converter has chosen the timer as its trigger source.

Top module: `tev_top`

## Requirements
- R1: After reset, all flags, enable bits, interrupt lines, `adc_start` and `reg_rdata` are 0.
- R2: Each interrupt line is 1 exactly one cycle after its flag and its enable bit are both 1, and 0 one cycle after either of them is 0.
- R3: An event strobe sets its flag at the next clock edge, whether or not its enable bit is set.
- R4: A flag changes from 1 to 0 only through a write of 0 to its bit after a status read that returned it as 1. A write of 0 without such a read leaves the flag set, and so does a write of 1.
- R5: If an event and a clearing write reach a flag in the same cycle, the flag stays 1.
- R6: Clearing an enable bit only masks its interrupt line and leaves the flag at 1. Setting the enable again raises the line again.
- R7: Channel c has its status register at address 2c and its enable register at 2c+1. In both registers, bits 0-3 are match A-D and bit 4 is overflow. Bit 5 is underflow. Bit 6 of the enable register is the trigger enable. `reg_rdata` is loaded one cycle after `reg_rd` and holds its value until the next read.
- R8: Bits a channel does not have always read 0 and cannot be set. This covers match C/D on channels 1 and 2, and underflow on channel 0. A written enable register of channel 0 reads 0x5F after a write of 0xFF, and one of channel 1 or 2 reads 0x73.
- R9: The match-A flag of a trigger-enabled channel rising from 0 to 1 gives a `adc_start` pulse of exactly one cycle, two edges after the event strobe. The pulse does not repeat while the flag stays 1.
- R10: No `adc_start` pulse is produced while `adc_sel` is 0.
- R11: Port bit mapping: `ev_match`/`irq_match` bits 0-3 are channel 0 A-D, bits 4-5 are channel 1 A-B and bits 6-7 are channel 2 A-B. `ev_unf`/`irq_unf` bit 0 is channel 1 and bit 1 is channel 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_match | input | 8 | Compare/capture match strobes |
| ev_ovf | input | 3 | Overflow strobes, one per channel |
| ev_unf | input | 2 | Underflow strobes for channels 1 and 2 |
| adc_sel | input | 1 | Converter has chosen the timer as its trigger source |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_match | output | 8 | Match interrupt requests |
| irq_ovf | output | 3 | Overflow interrupt requests |
| irq_unf | output | 2 | Underflow interrupt requests |
| adc_start | output | 1 | One-cycle conversion-start pulse |

## Verification
Four properties are checked on every cycle:
- each interrupt line equals the previous cycle's flag-and-enable product;
- a strobe always leaves its flag set;
- no flag falls without a status write;
- a start pulse never appears without the select having been high.

Other behaviours depend on a sequence of register accesses and only the bench's scenarios can show them. These are the read-before-clear protocol, the event winning over a clear, the absent bits per channel, and the single start pulse while the flag stays high.

// File: rtl/tev_pkg.sv
package tev_pkg;
    typedef enum logic [1:0] {
        FL_IDLE,
        FL_PEND,
        FL_ARMED
    } flag_state_t;

    localparam int MAX_MATCH = 4;
    localparam int BIT_OVF   = 4;
    localparam int BIT_UNF   = 5;
    localparam int BIT_TRG   = 6;
    localparam int NSRC      = 6;

    function automatic int match_cnt(input int ch);
        return (ch == 0) ? 4 : 2;
    endfunction

    function automatic int match_base(input int ch);
        return (ch == 0) ? 0 : 2 * ch + 2;
    endfunction
endpackage

// File: rtl/tev_flag.sv
module tev_flag
    import tev_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic wr_bit,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (ev) state_d = FL_PEND;
            FL_PEND:  if (rd_hit) state_d = FL_ARMED;
            FL_ARMED: if (wr_hit && !wr_bit && !ev) state_d = FL_IDLE;
            default:  state_d = FL_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q != FL_IDLE);
    end
endmodule

// File: rtl/tev_channel.sv
module tev_channel
    import tev_pkg::*;
#(
    parameter int CH = 0,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAX_MATCH-1:0] ev_match,
    input  logic                 ev_ovf,
    input  logic                 ev_unf,
    input  logic                 st_rd,
    input  logic                 st_wr,
    input  logic                 en_wr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        status,
    output logic [DW-1:0]        enable,
    output logic [NSRC-1:0]      irq_out,
    output logic                 rise_a
);
    localparam int NM      = match_cnt(CH);
    localparam bit HAS_UNF = (CH > 0);
    localparam logic [DW-1:0] EN_MASK =
        DW'((1 << NM) - 1) | DW'(1 << BIT_OVF) | DW'(1 << BIT_TRG) |
        (HAS_UNF ? DW'(1 << BIT_UNF) : DW'(0));

    logic [MAX_MATCH-1:0] mflag;
    logic                 oflag, uflag, flag_a_q;
    logic [DW-1:0]        en_q;

    for (genvar i = 0; i < MAX_MATCH; i++) begin : g_match
        if (i < NM) begin : g_on
            tev_flag u_fl (
                .clk(clk), .rst_n(rst_n), .ev(ev_match[i]),
                .rd_hit(st_rd), .wr_hit(st_wr), .wr_bit(wdata[i]),
                .flag(mflag[i])
            );
        end else begin : g_off
            assign mflag[i] = 1'b0;
        end
    end

    tev_flag u_ovf (
        .clk(clk), .rst_n(rst_n), .ev(ev_ovf),
        .rd_hit(st_rd), .wr_hit(st_wr), .wr_bit(wdata[BIT_OVF]),
        .flag(oflag)
    );

    if (HAS_UNF) begin : g_unf
        tev_flag u_unf (
            .clk(clk), .rst_n(rst_n), .ev(ev_unf),
            .rd_hit(st_rd), .wr_hit(st_wr), .wr_bit(wdata[BIT_UNF]),
            .flag(uflag)
        );
    end else begin : g_nounf
        assign uflag = 1'b0;
    end

    always_comb begin
        status                = '0;
        status[MAX_MATCH-1:0] = mflag;
        status[BIT_OVF]       = oflag;
        status[BIT_UNF]       = uflag;
    end

    assign enable = en_q;
    assign rise_a = status[0] & ~flag_a_q & en_q[BIT_TRG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            irq_out  <= '0;
            flag_a_q <= 1'b0;
        end else begin
            if (en_wr) en_q <= wdata & EN_MASK;
            irq_out  <= status[NSRC-1:0] & en_q[NSRC-1:0];
            flag_a_q <= status[0];
        end
    end
endmodule

// File: rtl/tev_top.sv
module tev_top
    import tev_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int DW     = 8,
    parameter int AW     = $clog2(2 * NCH),
    parameter int NMATCH = 4 + 2 * (NCH - 1),
    parameter int NUNF   = NCH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NMATCH-1:0] ev_match,
    input  logic [NCH-1:0]    ev_ovf,
    input  logic [NUNF-1:0]   ev_unf,
    input  logic              adc_sel,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [NMATCH-1:0] irq_match,
    output logic [NCH-1:0]    irq_ovf,
    output logic [NUNF-1:0]   irq_unf,
    output logic              adc_start
);
    logic [DW-1:0] ch_status [NCH];
    logic [DW-1:0] ch_enable [NCH];
    logic [NCH-1:0] rise_vec;
    logic [DW-1:0] rd_sel;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int NM = match_cnt(c);
        localparam int MB = match_base(c);
        logic [MAX_MATCH-1:0] evm;
        logic                 evu;
        logic [NSRC-1:0]      irq;
        logic                 st_rd, st_wr, en_wr;

        assign st_rd = reg_rd && (reg_addr == AW'(2 * c));
        assign st_wr = reg_wr && (reg_addr == AW'(2 * c));
        assign en_wr = reg_wr && (reg_addr == AW'(2 * c + 1));

        for (genvar i = 0; i < MAX_MATCH; i++) begin : g_m
            if (i < NM) begin : g_on
                assign evm[i]            = ev_match[MB + i];
                assign irq_match[MB + i] = irq[i];
            end else begin : g_off
                assign evm[i] = 1'b0;
            end
        end

        if (c > 0) begin : g_u
            assign evu          = ev_unf[c - 1];
            assign irq_unf[c-1] = irq[BIT_UNF];
        end else begin : g_nu
            assign evu = 1'b0;
        end

        assign irq_ovf[c] = irq[BIT_OVF];

        tev_channel #(.CH(c), .DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n), .ev_match(evm), .ev_ovf(ev_ovf[c]),
            .ev_unf(evu), .st_rd(st_rd), .st_wr(st_wr), .en_wr(en_wr),
            .wdata(reg_wdata), .status(ch_status[c]), .enable(ch_enable[c]),
            .irq_out(irq), .rise_a(rise_vec[c])
        );
    end

    always_comb begin
        rd_sel = '0;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == AW'(2 * c))     rd_sel = ch_status[c];
            if (reg_addr == AW'(2 * c + 1)) rd_sel = ch_enable[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            adc_start <= 1'b0;
        end else begin
            if (reg_rd) reg_rdata <= rd_sel;
            adc_start <= adc_sel & (|rise_vec);
        end
    end
endmodule

// File: rtl/tev_checkers.sv
module tev_chk_channel
    import tev_pkg::*;
#(
    parameter int DW = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [MAX_MATCH-1:0] ev_match,
    input logic                 ev_ovf,
    input logic                 st_wr,
    input logic [DW-1:0]        status,
    input logic [DW-1:0]        enable,
    input logic [NSRC-1:0]      irq_out,
    input logic                 rise_a
);
    // R2: line follows last cycle's flag and enable
    a_r2_irq_masked_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(status[NSRC-1:0] & enable[NSRC-1:0]));

    // R3 and R5: a strobe always leaves its flag set, even against a clear
    a_r3_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_match) |=> ((status[MAX_MATCH-1:0] & $past(ev_match)) == $past(ev_match)));

    a_r5_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovf |=> status[BIT_OVF]);

    // R4: without a status write no flag falls
    a_r4_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !st_wr |=> (($past(status[NSRC-1:0]) & ~status[NSRC-1:0]) == '0));

    // R9: a rise request lasts one cycle
    a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise_a |=> !rise_a);
endmodule

module tev_chk_top (
    input logic clk,
    input logic rst_n,
    input logic adc_sel,
    input logic adc_start
);
    // R10: no start pulse unless the select was high
    a_r10_start_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(adc_sel));
endmodule

bind tev_channel tev_chk_channel #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_match(ev_match), .ev_ovf(ev_ovf),
    .st_wr(st_wr), .status(status), .enable(enable),
    .irq_out(irq_out), .rise_a(rise_a)
);

bind tev_top tev_chk_top u_chk_top (
    .clk(clk), .rst_n(rst_n), .adc_sel(adc_sel), .adc_start(adc_start)
);

// File: tb/sim_tev_top.sv
module sim_tev_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ev_match = '0;
    logic [2:0] ev_ovf = '0;
    logic [1:0] ev_unf = '0;
    logic       adc_sel = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] irq_match;
    logic [2:0] irq_ovf;
    logic [1:0] irq_unf;
    logic       adc_start;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // {event strobes, expected irq_match} with enables ch0=0x07 ch1=0x03 ch2=0x01
    localparam logic [15:0] VEC [6] = '{16'h0101, 16'h0800, 16'h8000,
                                        16'h3030, 16'hFF77, 16'h4444};

    tev_top u0 (
        .clk(clk), .rst_n(rst_n), .ev_match(ev_match), .ev_ovf(ev_ovf),
        .ev_unf(ev_unf), .adc_sel(adc_sel), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_match(irq_match), .irq_ovf(irq_ovf),
        .irq_unf(irq_unf), .adc_start(adc_start)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        for (int c = 0; c < 3; c++) begin
            rd(3'(2 * c), d);
            wr(3'(2 * c), 8'h00);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] ev, exp;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 irq_match", irq_match, 0);
        check("R1 irq_ovf", irq_ovf, 0);
        check("R1 irq_unf", irq_unf, 0);
        check("R1 adc_start", adc_start, 0);
        check("R1 rdata", reg_rdata, 0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R1 register", d, 0);
        end

        // R2 R3 R11 vector table
        wr(3'd1, 8'h07);
        wr(3'd3, 8'h03);
        wr(3'd5, 8'h01);
        for (int k = 0; k < 6; k++) begin
            ev = VEC[k][15:8];
            exp = VEC[k][7:0];
            ev_match = ev;
            step();
            ev_match = '0;
            step();
            check("R2/R11 irq_match", irq_match, exp);
            rd(3'd0, d); check("R3 ch0 status", d, {4'b0, ev[3:0]});
            rd(3'd2, d); check("R3 ch1 status", d, {6'b0, ev[5:4]});
            rd(3'd4, d); check("R3 ch2 status", d, {6'b0, ev[7:6]});
            for (int c = 0; c < 3; c++) wr(3'(2 * c), 8'h00);
            step(); step();
            check("R2 irq drops after clear", irq_match, 0);
        end
        wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h00);

        // R4 clear protocol
        ev_match = 8'h10; step(); ev_match = '0;
        wr(3'd2, 8'h00);
        rd(3'd2, d); check("R4 unread write-0 ignored", d, 8'h01);
        wr(3'd2, 8'h01);
        rd(3'd2, d); check("R4 write-1 ignored", d, 8'h01);
        wr(3'd2, 8'h00);
        rd(3'd2, d); check("R4 read then write-0 clears", d, 8'h00);

        // R5 event wins over clear
        ev_match = 8'h80; step(); ev_match = '0;
        rd(3'd4, d); check("R5 flag read", d, 8'h02);
        ev_match = 8'h80;
        wr(3'd4, 8'h00);
        ev_match = '0;
        rd(3'd4, d); check("R5 event beats clear", d, 8'h02);
        clear_all();
        rd(3'd4, d); check("R5 later clear", d, 8'h00);

        // R6 masking
        wr(3'd1, 8'h10);
        ev_ovf = 3'b001; step(); ev_ovf = '0;
        step();
        check("R6 irq_ovf on", irq_ovf, 3'b001);
        wr(3'd1, 8'h00);
        step();
        check("R6 masked", irq_ovf, 3'b000);
        rd(3'd0, d); check("R6 flag kept", d, 8'h10);
        wr(3'd1, 8'h10);
        step();
        check("R6 re-enabled", irq_ovf, 3'b001);
        wr(3'd0, 8'h00);
        step();
        check("R6 cleared", irq_ovf, 3'b000);

        // R8 absent bits, R7 map and hold
        wr(3'd1, 8'hFF);
        rd(3'd1, d); check("R8 ch0 enable", d, 8'h5F);
        wr(3'd3, 8'hFF);
        rd(3'd3, d); check("R8 ch1 enable", d, 8'h73);
        wr(3'd5, 8'h41);
        rd(3'd5, d); check("R7 ch2 enable", d, 8'h41);
        step();
        check("R7 rdata holds", reg_rdata, 8'h41);
        ev_unf = 2'b01; step(); ev_unf = '0;
        step();
        check("R8/R11 irq_unf ch1", irq_unf, 2'b01);
        rd(3'd2, d); check("R8 ch1 underflow flag", d, 8'h20);
        rd(3'd0, d); check("R8 ch0 no underflow", d, 8'h00);
        wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h00);
        clear_all();

        // R9 start pulse
        wr(3'd3, 8'h40);
        adc_sel = 1'b1;
        ev_match = 8'h10; step(); ev_match = '0;
        check("R9 not yet", adc_start, 0);
        step(); check("R9 pulse", adc_start, 1);
        step(); check("R9 one cycle", adc_start, 0);
        step(); check("R9 no repeat", adc_start, 0);
        clear_all();

        // R10 select gating
        adc_sel = 1'b0;
        ev_match = 8'h10; step(); ev_match = '0;
        step(); check("R10 gated", adc_start, 0);
        step(); check("R10 gated later", adc_start, 0);
        clear_all();

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule